// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the management-side slave of a Clause 22 serial management bus. It oversamples the management clock and data line with its own system clock, recognises read and write frames whose PHY address field equals the address captured from strap inputs at reset, and turns them into accesses on a simple internal register port. That port presents a 5-bit register address, 16-bit write data and a one-cycle write strobe. Read data comes back from the register owner on a separate input. The register owner sits outside this block. Only the return of zero for the unimplemented addresses 7 to 15 is handled inside.

The data line is driven only while a read frame is returning its turnaround and data bits. A control input lets the station omit the preamble, so a frame may start straight after any idle bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is held and on the cycle after it, `mdio_oe` and `reg_we` are 0.
- R2: In a matching read frame the slave leaves the line undriven (`mdio_oe`=0) during the first turnaround bit and drives 0 (`mdio_oe`=1, `mdio_out`=0) during the second.
- R3: In a matching read frame the 16 data bits are driven most significant bit first, taken from `reg_rdata` for the register address of the frame, with `mdio_oe`=1 in every data bit period. Outputs change only after a rising MDC edge.
- R4: A read of register addresses 7 to 15 returns 16 zero bits whatever `reg_rdata` holds. Addresses 6 and 16 return the register value.
- R5: A matching write frame produces exactly one `reg_we` pulse of one clock, after the sixteenth data bit is sampled, with `reg_addr` equal to the frame's register field and `reg_wdata` equal to its data field. The slave never drives the line during a write.
- R6: A frame whose PHY address field differs from the captured address causes no drive and no write.
- R7: Only opcode bits 10 (read) and 01 (write), first bit on the left, are accepted. Opcodes 00 and 11 cause no drive and no write.
- R8: With `pre_bypass`=0 a start pattern (0 then 1) is accepted only after at least 32 consecutive 1 bits. After 31 ones the frame is ignored.
- R9: With `pre_bypass`=1 a frame with no preamble at all is accepted, for both reads and writes.
- R10: The matching address is `phy_strap` as held during reset. Changing `phy_strap` after reset has no effect.
- R11: The slave releases the line (`mdio_oe`=0) in the bit period after the last read data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Management data line as seen at the pad |
| mdio_out | output | 1 | Value driven on the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| phy_strap | input | 5 | PHY address strap, captured during reset |
| pre_bypass | input | 1 | 1: frames need no preamble |
| reg_addr | output | 5 | Register port address |
| reg_wdata | output | 16 | Register port write data |
| reg_we | output | 1 | Register port write strobe, one clock |
| reg_rdata | input | 16 | Register port read data for `reg_addr` |

## Verification
The hardest state to reach from the ports is the boundary between an accepted and a refused preamble: the trailing idle bits of an earlier frame count toward the next preamble, so the bench first sends a single 0 to clear the count, then offers exactly 31 ones and afterwards exactly 32. The preamble-free path is reached by raising the bypass input and issuing frames that start with a 0 right after an idle bit. The strap-capture path is reached by changing the strap after reset and addressing both the old and the new value.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_OP, ST_PHY, ST_REG, ST_TA, ST_RD, ST_WR
  } mdio_st_e;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_in,
  output logic mdc_rise,
  output logic bit_val
);
  logic [SYNC_STAGES:0]   mdc_sh;
  logic [SYNC_STAGES-1:0] dat_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_sh <= '0;
      dat_sh <= '1;
    end else begin
      mdc_sh <= {mdc_sh[SYNC_STAGES-1:0], mdc};
      dat_sh <= {dat_sh[SYNC_STAGES-2:0], mdio_in};
    end
  end

  // clock and data pass through equal depth so they stay aligned
  assign mdc_rise = mdc_sh[SYNC_STAGES-1] & ~mdc_sh[SYNC_STAGES];
  assign bit_val  = dat_sh[SYNC_STAGES-1];
endmodule

// File: rtl/mdio_rd_filter.sv
module mdio_rd_filter #(
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int HOLE_LO = 7,
  parameter int HOLE_HI = 15
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rdata_in,
  output logic [DW-1:0] rdata_out
);
  localparam logic [AW-1:0] LO = AW'(HOLE_LO);
  localparam logic [AW-1:0] HI = AW'(HOLE_HI);

  always_comb begin
    if (addr >= LO && addr <= HI) rdata_out = '0;
    else                          rdata_out = rdata_in;
  end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slave_pkg::*;
#(
  parameter int PW      = 5,
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mdc_rise,
  input  logic          bit_val,
  input  logic          pre_bypass,
  input  logic [PW-1:0] phy_addr,
  input  logic [DW-1:0] rd_word,
  output logic          mdio_oe,
  output logic          mdio_out,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          rd_phase
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int CW  = $clog2(DW);
  localparam logic [PCW-1:0] PRE_MAX = PCW'(PRE_LEN);

  mdio_st_e       st;
  logic [PCW-1:0] ones_cnt;
  logic [CW-1:0]  bit_cnt;
  logic [1:0]     op_q;
  logic [PW-2:0]  phy_sh;
  logic [DW-1:0]  shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      ones_cnt <= '0;
      bit_cnt  <= '0;
      op_q     <= '0;
      phy_sh   <= '0;
      reg_addr <= '0;
      shreg    <= '0;
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
      reg_we   <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (mdc_rise) begin
        case (st)
          ST_HUNT: begin
            if (bit_val) begin
              if (ones_cnt != PRE_MAX) ones_cnt <= ones_cnt + 1'b1;
            end else if (ones_cnt == PRE_MAX || pre_bypass) begin
              st <= ST_START;
            end else begin
              ones_cnt <= '0;
            end
          end
          ST_START: begin
            ones_cnt <= '0;
            bit_cnt  <= '0;
            st       <= bit_val ? ST_OP : ST_HUNT;
          end
          ST_OP: begin
            op_q <= {op_q[0], bit_val};
            if (bit_cnt == CW'(1)) begin
              bit_cnt <= '0;
              if ({op_q[0], bit_val} == OP_RD || {op_q[0], bit_val} == OP_WR)
                st <= ST_PHY;
              else
                st <= ST_HUNT;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_PHY: begin
            phy_sh <= {phy_sh[PW-3:0], bit_val};
            if (bit_cnt == CW'(PW - 1)) begin
              bit_cnt <= '0;
              st      <= ({phy_sh, bit_val} == phy_addr) ? ST_REG : ST_HUNT;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_REG: begin
            reg_addr <= {reg_addr[AW-2:0], bit_val};
            if (bit_cnt == CW'(AW - 1)) begin
              bit_cnt <= '0;
              st      <= ST_TA;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_TA: begin
            if (bit_cnt == '0) begin
              bit_cnt <= CW'(1);
              if (op_q == OP_RD) begin
                mdio_oe  <= 1'b1;
                mdio_out <= 1'b0;
              end
            end else begin
              bit_cnt <= '0;
              if (op_q == OP_RD) begin
                st       <= ST_RD;
                mdio_out <= rd_word[DW-1];
                shreg    <= {rd_word[DW-2:0], 1'b0};
              end else begin
                st <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (bit_cnt == CW'(DW - 1)) begin
              bit_cnt  <= '0;
              st       <= ST_HUNT;
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b0;
            end else begin
              bit_cnt  <= bit_cnt + 1'b1;
              mdio_out <= shreg[DW-1];
              shreg    <= {shreg[DW-2:0], 1'b0};
            end
          end
          ST_WR: begin
            shreg <= {shreg[DW-2:0], bit_val};
            if (bit_cnt == CW'(DW - 1)) begin
              bit_cnt <= '0;
              st      <= ST_HUNT;
              reg_we  <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  assign reg_wdata = shreg;
  assign rd_phase  = (st == ST_RD);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int PW          = 5,
  parameter int AW          = 5,
  parameter int DW          = 16,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int HOLE_LO     = 7,
  parameter int HOLE_HI     = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mdc,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe,
  input  logic [PW-1:0] phy_strap,
  input  logic          pre_bypass,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  logic          mdc_rise;
  logic          bit_val;
  logic [PW-1:0] phy_q;
  logic [DW-1:0] rd_word;
  logic          rd_phase;

  // address is taken from the straps only while reset is held
  always_ff @(posedge clk) begin
    if (rst) phy_q <= phy_strap;
  end

  mdio_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(mdio_in),
    .mdc_rise(mdc_rise), .bit_val(bit_val)
  );

  mdio_rd_filter #(.AW(AW), .DW(DW), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_filt (
    .addr(reg_addr), .rdata_in(reg_rdata), .rdata_out(rd_word)
  );

  mdio_frame_fsm #(.PW(PW), .AW(AW), .DW(DW), .PRE_LEN(PRE_LEN)) u_fsm (
    .clk(clk), .rst(rst), .mdc_rise(mdc_rise), .bit_val(bit_val),
    .pre_bypass(pre_bypass), .phy_addr(phy_q), .rd_word(rd_word),
    .mdio_oe(mdio_oe), .mdio_out(mdio_out), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .rd_phase(rd_phase)
  );
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk #(
  parameter int PW      = 5,
  parameter int AW      = 5,
  parameter int HOLE_LO = 7,
  parameter int HOLE_HI = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          mdc_rise,
  input logic          mdio_oe,
  input logic          mdio_out,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [PW-1:0] phy_q,
  input logic          rd_phase
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!mdio_oe && !reg_we));

  p_oe_after_edge_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_oe) |-> $past(mdc_rise));

  p_out_after_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_out) |-> $past(mdc_rise));

  p_hole_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_phase && reg_addr >= AW'(HOLE_LO) && reg_addr <= AW'(HOLE_HI)) |-> !mdio_out);

  p_we_single_r5: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we);

  p_we_no_drive_r5: assert property (@(posedge clk) disable iff (rst) reg_we |-> !mdio_oe);

  p_addr_held_r10: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> $stable(phy_q));
endmodule

bind mdio_mgmt_slave mdio_slave_chk #(.PW(PW), .AW(AW), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_chk (
  .clk(clk), .rst(rst), .mdc_rise(mdc_rise), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .reg_we(reg_we), .reg_addr(reg_addr), .phy_q(phy_q), .rd_phase(rd_phase)
);

// File: tb/sim_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_slave;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b0;
  logic        mdio_in = 1'b1;
  logic        mdio_out, mdio_oe, reg_we;
  logic [4:0]  phy_strap = 5'h13;
  logic        pre_bypass = 1'b0;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  logic [15:0] bank [32];
  logic [15:0] model [32];
  int          we_count = 0;
  logic [4:0]  we_addr;
  logic [15:0] we_data;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mdio_mgmt_slave u0 (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(mdio_in), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .phy_strap(phy_strap), .pre_bypass(pre_bypass),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // register owner outside the slave
  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) bank[i] <= 16'(i * 257) ^ 16'hC3A5;
    end else if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
      we_addr  <= reg_addr;
      we_data  <= reg_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_rd(input logic [4:0] a);
    return (a >= 5'd7 && a <= 5'd15) ? 16'h0000 : model[a];
  endfunction

  task automatic clock_bit(input logic b, output logic oe, output logic dout);
    @(negedge clk) mdio_in = b;
    repeat (HP) @(posedge clk);
    @(negedge clk);
    oe = mdio_oe; dout = mdio_out;
    mdc = 1'b1;
    repeat (HP) @(posedge clk);
    @(negedge clk) mdc = 1'b0;
  endtask

  logic        f_ta1, f_ta2_oe, f_ta2_out, f_dat_oe, f_any, f_tail;
  logic [15:0] f_rd;
  int          f_we;

  task automatic frame(input int npre, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd);
    logic oe, d;
    int base;
    logic [13:0] hdr;
    base = we_count;
    f_any = 0; f_dat_oe = 1; f_rd = '0;
    hdr = {2'b01, op, pa, ra};
    for (int i = 0; i < npre; i++) begin clock_bit(1'b1, oe, d); f_any |= oe; end
    for (int i = 13; i >= 0; i--) begin clock_bit(hdr[i], oe, d); f_any |= oe; end
    clock_bit(1'b1, oe, d); f_ta1 = oe; f_any |= oe;
    clock_bit(op == 2'b10 ? 1'b1 : 1'b0, oe, d); f_ta2_oe = oe; f_ta2_out = d; f_any |= oe;
    for (int i = 15; i >= 0; i--) begin
      clock_bit(op == 2'b10 ? 1'b1 : wd[i], oe, d);
      f_any |= oe; f_dat_oe &= oe; f_rd[i] = d;
    end
    clock_bit(1'b1, oe, d); f_tail = oe; f_any |= oe;
    f_we = we_count - base;
  endtask

  task automatic rd_ok(input logic [4:0] pa, input logic [4:0] ra, input string req);
    frame(32, 2'b10, pa, ra, 16'h0);
    check(f_rd === expect_rd(ra), req, "read data", f_rd, expect_rd(ra));
    check(f_dat_oe === 1'b1, req, "drive during data", f_dat_oe, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic oe, d;
    for (int i = 0; i < 32; i++) model[i] = 16'(i * 257) ^ 16'hC3A5;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(mdio_oe === 1'b0 && reg_we === 1'b0, "R1", "reset outputs", {mdio_oe, reg_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(mdio_oe === 1'b0 && reg_we === 1'b0, "R1", "after reset", {mdio_oe, reg_we}, 0);
    phy_strap = 5'h05;   // R10: change after reset must not matter

    // R2 R3 R11: plain read
    frame(32, 2'b10, 5'h13, 5'd2, 16'h0);
    check(f_ta1 === 1'b0, "R2", "first turnaround released", f_ta1, 0);
    check(f_ta2_oe === 1'b1 && f_ta2_out === 1'b0, "R2", "second turnaround low", {f_ta2_oe, f_ta2_out}, 2);
    check(f_rd === expect_rd(5'd2), "R3", "read reg 2", f_rd, expect_rd(5'd2));
    check(f_dat_oe === 1'b1, "R3", "drive in data", f_dat_oe, 1);
    check(f_tail === 1'b0, "R11", "release after data", f_tail, 0);

    // R5: write then read back
    frame(32, 2'b01, 5'h13, 5'd4, 16'hBEEF);
    model[4] = 16'hBEEF;
    check(f_we == 1, "R5", "strobe count", f_we, 1);
    check(we_addr === 5'd4 && we_data === 16'hBEEF, "R5", "strobe addr/data", {we_addr, we_data}, {5'd4, 16'hBEEF});
    check(f_any === 1'b0, "R5", "no drive in write", f_any, 0);
    rd_ok(5'h13, 5'd4, "R3");
    frame(32, 2'b01, 5'h13, 5'd31, 16'h0001);
    model[31] = 16'h0001;
    check(f_we == 1 && we_addr === 5'd31, "R5", "write reg 31", we_addr, 31);
    rd_ok(5'h13, 5'd31, "R3");

    // R4: hole returns zero, edges of the hole return data
    rd_ok(5'h13, 5'd7, "R4");
    rd_ok(5'h13, 5'd9, "R4");
    rd_ok(5'h13, 5'd15, "R4");
    rd_ok(5'h13, 5'd6, "R4");
    rd_ok(5'h13, 5'd16, "R4");

    // R6: other address
    frame(32, 2'b10, 5'h12, 5'd2, 16'h0);
    check(f_any === 1'b0, "R6", "no drive on mismatch", f_any, 0);
    frame(32, 2'b01, 5'h12, 5'd3, 16'h1234);
    check(f_we == 0 && f_any === 1'b0, "R6", "no write on mismatch", f_we, 0);

    // R7: bad opcodes
    frame(32, 2'b00, 5'h13, 5'd3, 16'h5555);
    check(f_we == 0 && f_any === 1'b0, "R7", "opcode 00 ignored", f_we, 0);
    frame(32, 2'b11, 5'h13, 5'd3, 16'h5555);
    check(f_we == 0 && f_any === 1'b0, "R7", "opcode 11 ignored", f_we, 0);
    rd_ok(5'h13, 5'd3, "R7");

    // R8: clear count with a 0, then 31 ones refused, 32 accepted
    clock_bit(1'b0, oe, d);
    frame(31, 2'b01, 5'h13, 5'd5, 16'h0A0A);
    check(f_we == 0 && f_any === 1'b0, "R8", "short preamble refused", f_we, 0);
    clock_bit(1'b0, oe, d);
    frame(32, 2'b01, 5'h13, 5'd5, 16'h0A0A);
    model[5] = 16'h0A0A;
    check(f_we == 1, "R8", "full preamble accepted", f_we, 1);

    // R9: no preamble with bypass on
    pre_bypass = 1'b1;
    frame(0, 2'b01, 5'h13, 5'd20, 16'h7E81);
    model[20] = 16'h7E81;
    check(f_we == 1 && we_data === 16'h7E81, "R9", "bypass write", we_data, 16'h7E81);
    frame(0, 2'b10, 5'h13, 5'd20, 16'h0);
    check(f_rd === 16'h7E81, "R9", "bypass read", f_rd, 16'h7E81);
    pre_bypass = 1'b0;

    // R10: new strap value not used
    frame(32, 2'b10, 5'h05, 5'd2, 16'h0);
    check(f_any === 1'b0, "R10", "post-reset strap ignored", f_any, 0);
    rd_ok(5'h13, 5'd1, "R10");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule